// File: doc/BRIEF.md
# Burst Address Sequencer with Order Select

This block produces the word address that a synchronous burst memory presents to its array. On each rising clock edge it either captures a fresh external address, moves one step through a four-word burst, or holds. Captures are requested through either of two strobes: one belongs to the processor side, the other to the memory controller side. A separate advance input moves the burst forward. Only the two lowest address bits take part in the burst, and the upper bits keep the value they were loaded with.

An order-select pin picks the stepping rule. Linear order adds the burst count to the starting low bits modulo four. Interleaved order XORs the starting low bits with the burst count. A new address may be captured on any cycle, including back to back, so no cycle is lost when bursts are not used.

A two-state controller sits behind the registers. `ST_EMPTY` is the state after reset, before any address has been captured. `ST_BURST` means a captured address is present. The transitions are:
- `EMPTY->BURST`: taken on a load.
- `BURST->BURST` (reload): taken on a load.
- `BURST->BURST` (step): taken on advance.
- `EMPTY->EMPTY` and `BURST->BURST` (hold): taken when neither a load nor an advance applies.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low and on the first edges after it, `word_addr` and `burst_pos` are 0. Advance pulses that arrive before any strobe leave both outputs at 0.
- R2: When `cpu_strobe` is 1 at a rising edge, `word_addr` equals the sampled `ext_addr` from the next cycle onward, and `burst_pos` becomes 0.
- R3: When `ctl_strobe` is 1 at a rising edge, `word_addr` equals the sampled `ext_addr` from the next cycle onward, and `burst_pos` becomes 0.
- R4: If both strobes are 1 at the same edge, one single load of `ext_addr` is performed. The processor strobe has priority in the decode.
- R5: A strobe overrides `adv`. A load with `adv` high gives the same result as a load with `adv` low.
- R6: With `order_lin`=1, each advance edge sets `word_addr[1:0]` to (start + count) mod 4, where count is the new `burst_pos`. For example, start 2 gives 2,3,0,1.
- R7: With `order_lin`=0, each advance edge sets `word_addr[1:0]` to start XOR count. For example, start 1 gives 1,0,3,2, and start 2 gives 2,3,0,1.
- R8: `word_addr[ADDR_W-1:2]` never changes on an advance. It changes only on a load.
- R9: `burst_pos` counts 0,1,2,3 and wraps to 0 on the fourth advance, which also brings the low bits back to the start value.
- R10: When neither strobe nor `adv` is 1, both outputs hold their values, even if `order_lin` changes.
- R11: Loads on consecutive cycles each take effect one cycle later, with no inserted wait cycle.
- R12: The stepping rule is sampled at each advance edge. The low bits are recomputed from the start value and the new count using the rule in force at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_strobe | input | 1 | Processor-side load strobe (higher priority) |
| ctl_strobe | input | 1 | Controller-side load strobe |
| adv | input | 1 | Burst advance |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| ext_addr | input | ADDR_W | External word address |
| word_addr | output | ADDR_W | Current word address |
| burst_pos | output | 2 | Number of advances since the last load, modulo 4 |

## Verification
The properties assume that every control input is a clean 0 or 1 at each rising edge, and that `ext_addr` is stable around a strobe edge. The bench changes every input only on the falling edge, so these assumptions hold. The interleaved check compares the low bits against the start value captured by the checker's own register. That comparison is only meaningful after a load, so the property is gated on that register. The stimulus includes advances before the first load, so the ungated case is exercised too.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } seq_cmd_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_BURST = 1'b1
    } seq_state_e;

endpackage

// File: rtl/bseq_cmd_arb.sv
module bseq_cmd_arb
    import bseq_pkg::*;
(
    input  logic     cpu_strobe,
    input  logic     ctl_strobe,
    input  logic     adv,
    output seq_cmd_e cmd
);
    // Processor strobe first, controller strobe second, advance last (R4, R5)
    always_comb begin
        if (cpu_strobe)      cmd = CMD_LOAD;
        else if (ctl_strobe) cmd = CMD_LOAD;
        else if (adv)        cmd = CMD_STEP;
        else                 cmd = CMD_HOLD;
    end
endmodule

// File: rtl/bseq_fsm.sv
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_cmd_e   cmd,
    output seq_state_e state,
    output logic       load_en,
    output logic       step_en
);
    seq_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (cmd == CMD_LOAD) state_nx = ST_BURST;
            ST_BURST: state_nx = ST_BURST;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    // Output decode: advance before any load is ignored (R1)
    always_comb begin
        load_en = 1'b0;
        step_en = 1'b0;
        unique case (state)
            ST_EMPTY: load_en = (cmd == CMD_LOAD);
            ST_BURST: begin
                load_en = (cmd == CMD_LOAD);
                step_en = (cmd == CMD_STEP);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bseq_order.sv
module bseq_order #(
    parameter int BW = 2
) (
    input  logic [BW-1:0] start,
    input  logic [BW-1:0] count,
    input  logic          order_lin,
    output logic [BW-1:0] low
);
    logic [BW-1:0] lin_v;
    logic [BW-1:0] ilv_v;

    assign lin_v = start + count;   // modulo 2**BW wrap (R6)
    assign ilv_v = start ^ count;   // R7
    assign low   = order_lin ? lin_v : ilv_v;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_strobe,
    input  logic              ctl_strobe,
    input  logic              adv,
    input  logic              order_lin,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] word_addr,
    output logic [1:0]        burst_pos
);
    localparam int LO_W = BURST_W;
    localparam int HI_W = ADDR_W - LO_W;

    seq_cmd_e      cmd;
    seq_state_e    state;
    logic          load_en;
    logic          step_en;
    logic [HI_W-1:0] hi_q;
    logic [LO_W-1:0] start_q;
    logic [LO_W-1:0] cnt_q;
    logic [LO_W-1:0] low_q;
    logic [LO_W-1:0] cnt_nx;
    logic [LO_W-1:0] low_nx;

    bseq_cmd_arb u_arb (
        .cpu_strobe (cpu_strobe),
        .ctl_strobe (ctl_strobe),
        .adv        (adv),
        .cmd        (cmd)
    );

    bseq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .state   (state),
        .load_en (load_en),
        .step_en (step_en)
    );

    assign cnt_nx = cnt_q + 1'b1;   // wraps after four steps (R9)

    bseq_order #(.BW(LO_W)) u_order (
        .start     (start_q),
        .count     (cnt_nx),
        .order_lin (order_lin),
        .low       (low_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            low_q   <= '0;
        end else if (load_en) begin
            hi_q    <= ext_addr[ADDR_W-1:LO_W];
            start_q <= ext_addr[LO_W-1:0];
            cnt_q   <= '0;
            low_q   <= ext_addr[LO_W-1:0];
        end else if (step_en) begin
            cnt_q   <= cnt_nx;
            low_q   <= low_nx;   // rule sampled at this edge (R12)
        end
    end

    assign word_addr = {hi_q, low_q};
    assign burst_pos = cnt_q;
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_strobe,
    input logic              ctl_strobe,
    input logic              adv,
    input logic              order_lin,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] word_addr,
    input logic [1:0]        burst_pos
);
    logic       seen_q;
    logic [1:0] st_q;
    logic       ld;

    assign ld = cpu_strobe | ctl_strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            st_q   <= 2'd0;
        end else if (ld) begin
            seen_q <= 1'b1;
            st_q   <= ext_addr[1:0];
        end
    end

    AST_CPU_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_strobe |=> (word_addr == $past(ext_addr) && burst_pos == 2'd0)); // R2
    AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_strobe && !cpu_strobe) |=> (word_addr == $past(ext_addr) && burst_pos == 2'd0)); // R3
    AST_STROBE_OVER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && adv) |=> burst_pos == 2'd0); // R5
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> word_addr[ADDR_W-1:2] == $past(word_addr[ADDR_W-1:2])); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv) |=> ($stable(word_addr) && $stable(burst_pos))); // R10
    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !ld && adv) |=> burst_pos == 2'($past(burst_pos) + 2'd1)); // R9
    AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !ld && adv && order_lin) |=> word_addr[1:0] == 2'(st_q + burst_pos)); // R6
    AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !ld && adv && !order_lin) |=> word_addr[1:0] == (st_q ^ burst_pos)); // R7
    AST_EMPTY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && !ld) |=> (word_addr == '0 && burst_pos == 2'd0)); // R1
endmodule

bind burst_addr_seq bseq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_strobe (cpu_strobe),
    .ctl_strobe (ctl_strobe),
    .adv        (adv),
    .order_lin  (order_lin),
    .ext_addr   (ext_addr),
    .word_addr  (word_addr),
    .burst_pos  (burst_pos)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;

    typedef struct {
        logic [AW-1:0] addr;
        logic [1:0]    pos;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_strobe = 1'b0;
    logic          ctl_strobe = 1'b0;
    logic          adv = 1'b0;
    logic          order_lin = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] word_addr;
    logic [1:0]    burst_pos;

    int n_run = 0;
    int n_fail = 0;
    exp_t sb[$];

    // bench-side reference state
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_cnt = '0;
    logic [1:0]    m_low = '0;
    logic          m_have = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_strobe (cpu_strobe),
        .ctl_strobe (ctl_strobe),
        .adv        (adv),
        .order_lin  (order_lin),
        .ext_addr   (ext_addr),
        .word_addr  (word_addr),
        .burst_pos  (burst_pos)
    );

    task automatic check(input string req, input logic [AW-1:0] a, input logic [1:0] p,
                         input logic [AW-1:0] ea, input logic [1:0] ep);
        n_run++;
        if (a !== ea || p !== ep) begin
            n_fail++;
            $display("FAIL %s: addr=%h pos=%0d expected addr=%h pos=%0d", req, a, p, ea, ep);
        end
    endtask

    // driver: apply one cycle of inputs and queue the expected result
    task automatic drive(input logic c, input logic k, input logic a, input logic o,
                         input logic [AW-1:0] ad, input string req);
        exp_t e;
        @(negedge clk);
        cpu_strobe = c; ctl_strobe = k; adv = a; order_lin = o; ext_addr = ad;
        if (c || k) begin
            m_base = ad; m_start = ad[1:0]; m_cnt = 2'd0; m_low = ad[1:0]; m_have = 1'b1;
        end else if (a && m_have) begin
            m_cnt = m_cnt + 2'd1;
            m_low = o ? 2'(m_start + m_cnt) : (m_start ^ m_cnt);
        end
        e.addr = {m_base[AW-1:2], m_low};
        e.pos  = m_cnt;
        e.req  = req;
        sb.push_back(e);
    endtask

    // monitor: compare a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, word_addr, burst_pos, e.addr, e.pos);
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        check("R1 in reset", word_addr, burst_pos, '0, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: advance before any load is ignored
        drive(0, 0, 1, 1, 20'hABCDE, "R1");
        drive(0, 0, 1, 0, 20'h12345, "R1");
        // R2 processor load, R6 linear from 2 -> 2,3,0,1 and wrap (R9)
        drive(1, 0, 0, 1, 20'h5A5A6, "R2");
        drive(0, 0, 1, 1, 20'h00000, "R6");
        drive(0, 0, 1, 1, 20'h00000, "R6");
        drive(0, 0, 1, 1, 20'h00000, "R6 R8");
        drive(0, 0, 1, 1, 20'h00000, "R9");
        // R10 hold with order toggling
        drive(0, 0, 0, 0, 20'hFFFFF, "R10");
        drive(0, 0, 0, 1, 20'h11111, "R10");
        // R3 controller load, R7 interleaved from 1 -> 1,0,3,2
        drive(0, 1, 0, 0, 20'h3C3C1, "R3");
        drive(0, 0, 1, 0, 20'h0, "R7");
        drive(0, 0, 1, 0, 20'h0, "R7");
        drive(0, 0, 1, 0, 20'h0, "R7 R8");
        drive(0, 0, 1, 0, 20'h0, "R9");
        // R7 interleaved from 2
        drive(1, 0, 0, 0, 20'h0F0F2, "R2");
        drive(0, 0, 1, 0, 20'h0, "R7");
        drive(0, 0, 1, 0, 20'h0, "R7");
        // R4 both strobes, R5 strobe with advance
        drive(1, 1, 0, 1, 20'h76543, "R4");
        drive(0, 0, 1, 1, 20'h0, "R6");
        drive(1, 0, 1, 1, 20'h24681, "R5");
        drive(0, 1, 1, 0, 20'h13579, "R5");
        // R11 back-to-back loads
        drive(1, 0, 0, 1, 20'h00003, "R11");
        drive(0, 1, 0, 1, 20'hFFFFC, "R11");
        drive(1, 0, 0, 1, 20'h80001, "R11");
        // R12 mode switch mid burst from start 1
        drive(0, 0, 1, 1, 20'h0, "R12");
        drive(0, 0, 1, 0, 20'h0, "R12");
        drive(0, 0, 1, 1, 20'h0, "R12");
        drive(0, 0, 1, 0, 20'h0, "R12");
        drive(0, 0, 0, 1, 20'h0, "R10");
        @(negedge clk);
        adv = 1'b0;
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule